// File: doc/BRIEF.md
# Low-Side Channel Enable Latch with Fault Blanking

This block holds the on/off state of a bank of low-side power switches. A control word that has already been shifted in arrives in parallel together with a one-cycle load strobe, which marks the end of a serial transfer. On that strobe every channel latch takes its new state, with a control bit of 0 meaning ON and 1 meaning OFF. The latch outputs drive the gate-enable lines of the switches.

Each switch has a saturation comparator that reports whether an enabled output has come out of saturation, which signals an overload or a short. Such a fault turns the affected channel off, one channel at a time. Lamps and inductive loads draw a large current when they start, so a blanking counter restarts on every load strobe. While it runs, fault flags cannot clear any latch. When it expires, any ON channel with its fault flag set is tripped off and stays off until a later load writes it ON again.

Top module: `olb_output_latch`

## Requirements
- R1: A synchronous active-high `rst` turns every gate enable off and ends blanking. It takes priority over a load strobe in the same cycle.
- R2: In the cycle after `load_stb` is high, gate enable bit i equals the inverse of `ctrl_byte` bit i, so a 0 turns the channel ON and a 1 turns it OFF.
- R3: After a load strobe, `blank_active` is high for exactly BLANK_CYC cycles and then falls.
- R4: A fault flag sampled while blanking is active never clears a gate enable.
- R5: Once blanking has ended, an ON channel whose fault flag is high is off in the following cycle.
- R6: A fault clears only its own channel. The other channels keep their state.
- R7: A channel cleared by a fault stays off after the fault goes away, until a load strobe writes a 0 to it.
- R8: A fault flag on a channel programmed OFF has no effect on any output.
- R9: A load strobe while blanking is active restarts the blanking count from its full length.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high clear of all channels and of the blanking counter |
| load_stb | input | 1 | One-cycle strobe that marks the end of a transfer |
| ctrl_byte | input | NCH | Control word; bit i is channel i, 0 = ON, 1 = OFF |
| fault_in | input | NCH | Out-of-saturation flag for each channel, active high |
| gate_en | output | NCH | Gate enable for each channel, 1 = switch conducting |
| blank_active | output | 1 | High while fault clearing is suppressed |

## Verification
The hardest case to reach from the ports is a restart: a second load strobe must arrive inside an open blanking window, with a fault already held on an ON channel. Only then can the bench tell a counter that reloads from one that keeps counting from the first strobe. The stimulus issues the second strobe a few cycles into the window and places expectations both at the cycle where the first window would have ended and at the cycle where the restarted window ends. The bench also times fault flags against the last blanked edge, so that the edge where a fault is ignored and the edge where it trips sit next to each other.

// File: rtl/olb_pkg.sv
package olb_pkg;
  typedef enum logic [1:0] {
    CH_OFF     = 2'd0,
    CH_ON      = 2'd1,
    CH_TRIPPED = 2'd2
  } ch_state_t;
endpackage

// File: rtl/olb_blank_timer.sv
module olb_blank_timer #(
  parameter int BLANK_CYC = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic active
);
  localparam int CW = $clog2(BLANK_CYC + 1);
  localparam logic [CW-1:0] RELOAD = CW'(BLANK_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (start)
      cnt_q <= RELOAD;
    else if (cnt_q != '0)
      cnt_q <= cnt_q - CW'(1);
  end

  assign active = (cnt_q != '0);

  // R3, R9: any strobe reloads the full window
  assert_reload_R3: assert property (@(posedge clk) disable iff (rst)
    start |=> (cnt_q == RELOAD));
  // R3: the count falls by one per cycle without a strobe
  assert_countdown_R3: assert property (@(posedge clk) disable iff (rst)
    (!start && active) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R1
  assert_idle_after_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !active);
endmodule

// File: rtl/olb_channel.sv
module olb_channel
  import olb_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic ctrl_bit,
  input  logic blank,
  input  logic fault,
  output logic gate_en
);
  ch_state_t state_q;

  always_ff @(posedge clk) begin
    if (rst)
      state_q <= CH_OFF;
    else if (load)
      state_q <= ctrl_bit ? CH_OFF : CH_ON;
    else if (state_q == CH_ON && fault && !blank)
      state_q <= CH_TRIPPED;
  end

  assign gate_en = (state_q == CH_ON);

  assert_off_after_clear_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> !gate_en);
  assert_load_polarity_R2: assert property (@(posedge clk) disable iff (rst)
    load |=> (gate_en == !$past(ctrl_bit)));
  assert_no_trip_blanked_R4: assert property (@(posedge clk) disable iff (rst)
    (!load && blank && gate_en) |=> gate_en);
  assert_trip_after_blank_R5: assert property (@(posedge clk) disable iff (rst)
    (!load && !blank && gate_en && fault) |=> !gate_en);
  assert_stays_off_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && !gate_en) |=> !gate_en);
endmodule

// File: rtl/olb_output_latch.sv
module olb_output_latch #(
  parameter int NCH       = 8,
  parameter int BLANK_CYC = 32
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load_stb,
  input  logic [NCH-1:0] ctrl_byte,
  input  logic [NCH-1:0] fault_in,
  output logic [NCH-1:0] gate_en,
  output logic           blank_active
);
  logic blank_w;

  olb_blank_timer #(.BLANK_CYC(BLANK_CYC)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .start  (load_stb),
    .active (blank_w)
  );

  assign blank_active = blank_w;

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    olb_channel u_ch (
      .clk      (clk),
      .rst      (rst),
      .load     (load_stb),
      .ctrl_bit (ctrl_byte[i]),
      .blank    (blank_w),
      .fault    (fault_in[i]),
      .gate_en  (gate_en[i])
    );
  end

  // R6, R8: the set of channels that drop is exactly the set of ON channels
  // that had a fault outside blanking
  assert_isolated_trip_R6: assert property (@(posedge clk) disable iff (rst)
    !load_stb |=> (($past(gate_en) & ~gate_en) ==
                   ($past(gate_en) & $past(fault_in) & {NCH{!$past(blank_active)}})));
endmodule

// File: tb/tb_olb_output_latch.sv
module tb_olb_output_latch;
  localparam int NCH = 8;
  localparam int B   = 12;

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           load_stb = 1'b0;
  logic [NCH-1:0] ctrl_byte = '1;
  logic [NCH-1:0] fault_in = '0;
  logic [NCH-1:0] gate_en;
  logic           blank_active;

  olb_output_latch #(.NCH(NCH), .BLANK_CYC(B)) dut (
    .clk(clk), .rst(rst), .load_stb(load_stb), .ctrl_byte(ctrl_byte),
    .fault_in(fault_in), .gate_en(gate_en), .blank_active(blank_active)
  );

  always #2.5 clk = ~clk;

  typedef struct {
    int             due;
    logic [NCH-1:0] gate;
    logic           blank;
    string          req;
  } exp_t;

  exp_t q[$];
  int   cyc = 0;
  int   n_checks = 0;
  int   n_fail = 0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  // monitor: compare every expectation due in this cycle
  always @(negedge clk) begin
    for (int k = q.size() - 1; k >= 0; k--) begin
      if (q[k].due <= cyc) begin
        n_checks++;
        if (q[k].due < cyc || gate_en !== q[k].gate || blank_active !== q[k].blank) begin
          n_fail++;
          $display("FAIL %s cyc %0d: gate=%h blank=%b expected gate=%h blank=%b",
                   q[k].req, cyc, gate_en, blank_active, q[k].gate, q[k].blank);
        end
        q.delete(k);
      end
    end
  end

  task automatic expect_at(input int due, input logic [NCH-1:0] g, input logic b,
                           input string r);
    exp_t e;
    e.due = due; e.gate = g; e.blank = b; e.req = r;
    q.push_back(e);
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic do_load(input logic [NCH-1:0] b);
    ctrl_byte = b;
    load_stb  = 1'b1;
    step(1);
    load_stb  = 1'b0;
  endtask

  initial begin : driver
    int base, base2, t;
    step(1);
    // reset state
    expect_at(cyc + 1, '0, 1'b0, "R1");
    step(2);
    rst = 1'b0;
    step(1);

    // load 0xA5 -> 0x5A ON; faults on ch0..3 (ch1,3 ON; ch0,2 OFF)
    base = cyc;
    fault_in = 8'h0F;
    expect_at(base + 1,     8'h5A, 1'b1, "R2");
    expect_at(base + B,     8'h5A, 1'b1, "R3");
    expect_at(base + B + 1, 8'h5A, 1'b0, "R4");
    expect_at(base + B + 2, 8'h50, 1'b0, "R5");
    expect_at(base + B + 3, 8'h50, 1'b0, "R6");
    do_load(8'hA5);
    step(B + 3);
    fault_in = '0;
    expect_at(cyc + 1, 8'h50, 1'b0, "R7");
    expect_at(cyc + 4, 8'h50, 1'b0, "R7");
    step(5);

    // restart of blanking by a second load
    base = cyc;
    fault_in = 8'h01;
    expect_at(base + 1, 8'h0F, 1'b1, "R2");
    do_load(8'hF0);
    step(4);
    base2 = cyc;
    expect_at(base2 + 1,     8'h0F, 1'b1, "R9");
    expect_at(base + B + 2,  8'h0F, 1'b1, "R9");
    expect_at(base2 + B,     8'h0F, 1'b1, "R9");
    expect_at(base2 + B + 1, 8'h0F, 1'b0, "R4");
    expect_at(base2 + B + 2, 8'h0E, 1'b0, "R5");
    do_load(8'hF0);
    step(B + 4);
    fault_in = '0;

    // all OFF with every fault set: nothing changes
    base = cyc;
    fault_in = '1;
    expect_at(base + 1,     8'h00, 1'b1, "R8");
    expect_at(base + B + 1, 8'h00, 1'b0, "R8");
    expect_at(base + B + 3, 8'h00, 1'b0, "R8");
    do_load(8'hFF);
    step(B + 4);
    fault_in = '0;

    // all ON, then a late fault on ch7 only
    base = cyc;
    expect_at(base + 1, 8'hFF, 1'b1, "R2");
    do_load(8'h00);
    step(B + 2);
    t = cyc;
    fault_in = 8'h80;
    expect_at(t + 1, 8'h7F, 1'b0, "R6");
    step(2);
    // reload writes ch7 ON again despite the held fault
    expect_at(cyc + 1, 8'hFF, 1'b1, "R7");
    do_load(8'h00);
    step(2);
    fault_in = '0;

    // clear wins over a simultaneous load
    rst = 1'b1;
    expect_at(cyc + 1, 8'h00, 1'b0, "R1");
    do_load(8'h00);
    rst = 1'b0;
    expect_at(cyc + 2, 8'h00, 1'b0, "R1");
    step(4);

    if (q.size() != 0) begin
      n_fail += q.size();
      $display("FAIL R1 %0d expectations never compared (actual left %0d, expected 0)",
               q.size(), q.size());
    end
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run hung (actual running, expected finished)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule